// File: doc/BRIEF.md
# Lane Width Negotiator With Reversal Fallback

This block picks the lane count and lane ordering that a multi-lane serial link port offers while its link trains. It reads a per-lane mask of lanes that carry training sets reliably, a configured width ceiling, a full-retrain pulse and a simplified answer from the partner. From these it produces a proposal: width, orientation and lowest physical lane used. It also drives a restart-from-Detect request and a negotiated-width status field.

When damaged lanes limit the link, the block tries the lane-reversed arrangement, but only if that gives more lanes than normal orientation. If the partner then fails lane numbering, training restarts and the next attempt uses normal orientation only. A successful link or a new full retrain lifts that restriction.

Receiver detection, ordered-set coding and the rest of the training state machine belong to the surrounding port.

Top module: `lane_width_neg`

## Requirements
- R1: While reset is held, and in the first cycle after release, `restart_detect` is 1 and `prop_valid`, `link_up` and `neg_width` are 0. The first proposal appears after the first clock edge following release.
- R2: The usable ceiling is the largest width in {1,2,4,8} not above `max_width`, capped at `LANES`. The normal width is the largest such width w, up to the ceiling, for which physical lanes 0..w-1 are all good. A normal proposal reports `cfg_reversed`=0 and `cfg_first_lane`=0.
- R3: The reversed width is the largest w, up to the ceiling C, for which lanes C-w..C-1 are all good. The block proposes reversal (`cfg_reversed`=1, `cfg_first_lane`=C-w) only when reversal is allowed and the reversed width is strictly greater than the normal width. For example, C=4 with only lane 1 bad gives a reversed x2 on lanes 2 and 3.
- R4: During a proposal, `partner_resp`=1 (accept) forms the link at the proposed configuration. `link_up` becomes 1 and `neg_width` shows the width.
- R5: `partner_resp`=2 (counter) with a `partner_width` that is a power of two, no larger than the ceiling, and whose lanes 0..w-1 are good, forms a normal-orientation link of that width starting at lane 0.
- R6: A counter request that fails those conditions is ignored. The proposal stays active and its width, orientation and first lane do not change.
- R7: `partner_resp`=3 (numbering failed) sends the block back to Detect, which raises `restart_detect` for one cycle. The next proposal and any later retry use normal orientation only, until the restriction is lifted.
- R8: The reversal restriction is lifted when a link forms or when `retrain` is pulsed.
- R9: A `retrain` pulse in any state clears `neg_width` and `link_up`, raises `restart_detect` for one cycle, and renegotiates with the current `max_width`.
- R10: If neither orientation has a usable lane, the block offers no proposal. `cfg_width`, `link_up` and `neg_width` stay 0 until the next `retrain`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_ok | input | LANES | Per-lane good mask, bit i = physical lane i |
| max_width | input | $clog2(LANES)+1 | Configured width ceiling |
| retrain | input | 1 | Full-retrain request pulse |
| partner_resp | input | 2 | 0 none, 1 accept, 2 counter, 3 numbering failed |
| partner_width | input | $clog2(LANES)+1 | Width requested by a counter response |
| prop_valid | output | 1 | A proposal is on offer |
| cfg_width | output | $clog2(LANES)+1 | Proposed or formed width |
| cfg_reversed | output | 1 | Lane-reversed arrangement |
| cfg_first_lane | output | $clog2(LANES) | Lowest physical lane used |
| restart_detect | output | 1 | Restart-from-Detect request |
| link_up | output | 1 | Link formed |
| neg_width | output | $clog2(LANES)+1 | Negotiated width status, 0 when down |

## Verification
A `retrain` pulse sampled at an edge makes `restart_detect` visible after that edge. The resulting proposal is visible after the next edge. A partner response sampled at an edge changes `link_up`, `neg_width` or the configuration after that same edge.

The bench drives each input on a falling edge and removes it on the next falling edge. It reads outputs only on falling edges, exactly one or two rising edges after the stimulus according to these latencies. Ignored stimuli are checked on the outputs one cycle after they were presented.

// File: rtl/lane_width_neg.sv
module lane_width_neg #(
  parameter int LANES = 8,
  localparam int WW = $clog2(LANES) + 1,
  localparam int LW = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_ok,
  input  logic [WW-1:0]    max_width,
  input  logic             retrain,
  input  logic [1:0]       partner_resp,
  input  logic [WW-1:0]    partner_width,
  output logic             prop_valid,
  output logic [WW-1:0]    cfg_width,
  output logic             cfg_reversed,
  output logic [LW-1:0]    cfg_first_lane,
  output logic             restart_detect,
  output logic             link_up,
  output logic [WW-1:0]    neg_width
);

  typedef enum logic [1:0] {ST_DETECT, ST_PROPOSE, ST_LINKED, ST_DOWN} st_t;

  localparam logic [1:0] RESP_ACC  = 2'd1;
  localparam logic [1:0] RESP_CTR  = 2'd2;
  localparam logic [1:0] RESP_FAIL = 2'd3;

  st_t st;
  logic rev_block;
  int cap, nrm, rev;
  logic ctr_ok, use_rev;
  logic [LANES-1:0] m;

  always_comb begin
    cap = 0;
    nrm = 0;
    rev = 0;
    ctr_ok = 1'b0;
    m = '0;
    for (int w = 1; w <= LANES; w = w * 2)
      if (w <= int'(max_width)) cap = w;
    for (int w = 1; w <= LANES; w = w * 2) begin
      m = LANES'((1 << w) - 1);
      if (w <= cap) begin
        if ((lane_ok & m) == m) nrm = w;
        if ((lane_ok & (m << (cap - w))) == (m << (cap - w))) rev = w;
        if (w == int'(partner_width) && (lane_ok & m) == m) ctr_ok = 1'b1;
      end
    end
  end

  assign use_rev = !rev_block && (rev > nrm);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st             <= ST_DETECT;
      rev_block      <= 1'b0;
      cfg_width      <= '0;
      cfg_reversed   <= 1'b0;
      cfg_first_lane <= '0;
      neg_width      <= '0;
    end else if (retrain) begin
      st        <= ST_DETECT;
      rev_block <= 1'b0;
      neg_width <= '0;
    end else begin
      case (st)
        ST_DETECT: begin
          if (use_rev) begin
            cfg_width      <= WW'(rev);
            cfg_reversed   <= 1'b1;
            cfg_first_lane <= LW'(cap - rev);
            st             <= ST_PROPOSE;
          end else begin
            cfg_width      <= WW'(nrm);
            cfg_reversed   <= 1'b0;
            cfg_first_lane <= '0;
            st             <= (nrm != 0) ? ST_PROPOSE : ST_DOWN;
          end
        end
        ST_PROPOSE: begin
          case (partner_resp)
            RESP_ACC: begin
              st        <= ST_LINKED;
              neg_width <= cfg_width;
              rev_block <= 1'b0;
            end
            RESP_CTR: if (ctr_ok) begin
              st             <= ST_LINKED;
              cfg_width      <= partner_width;
              cfg_reversed   <= 1'b0;
              cfg_first_lane <= '0;
              neg_width      <= partner_width;
              rev_block      <= 1'b0;
            end
            RESP_FAIL: begin
              st        <= ST_DETECT;
              rev_block <= 1'b1;
            end
            default: ;
          endcase
        end
        default: ;
      endcase
    end
  end

  assign prop_valid     = (st == ST_PROPOSE);
  assign restart_detect = (st == ST_DETECT);
  assign link_up        = (st == ST_LINKED);

  // R4
  accept_forms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_valid && partner_resp == RESP_ACC && !retrain) |=> (link_up && neg_width == $past(cfg_width)));

  // R7
  fail_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_valid && partner_resp == RESP_FAIL && !retrain) |=> (restart_detect && rev_block));

  // R7
  no_rev_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_valid && cfg_reversed) |-> !rev_block);

  // R9
  retrain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retrain |=> (restart_detect && !link_up && neg_width == '0 && !rev_block));

  // R2
  width_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> ($onehot(neg_width) && neg_width == cfg_width));

endmodule

// File: tb/tb_lane_width_neg.sv
`timescale 1ns/1ps
module tb_lane_width_neg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] lane_ok = 8'hFF;
  logic [3:0] max_width = 4'd8;
  logic retrain = 1'b0;
  logic [1:0] partner_resp = 2'd0;
  logic [3:0] partner_width = 4'd0;
  logic prop_valid, cfg_reversed, restart_detect, link_up;
  logic [3:0] cfg_width, neg_width;
  logic [2:0] cfg_first_lane;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  lane_width_neg #(.LANES(8)) dut (
    .clk(clk), .rst_n(rst_n), .lane_ok(lane_ok), .max_width(max_width),
    .retrain(retrain), .partner_resp(partner_resp), .partner_width(partner_width),
    .prop_valid(prop_valid), .cfg_width(cfg_width), .cfg_reversed(cfg_reversed),
    .cfg_first_lane(cfg_first_lane), .restart_detect(restart_detect),
    .link_up(link_up), .neg_width(neg_width));

  // {lane_ok, max_width, exp width, exp reversed, exp first lane}
  localparam int NV = 11;
  localparam logic [19:0] VEC [NV] = '{
    {8'hFF, 4'd8, 4'd8, 1'b0, 3'd0},
    {8'hFF, 4'd4, 4'd4, 1'b0, 3'd0},
    {8'hF0, 4'd8, 4'd4, 1'b1, 3'd4},
    {8'h0D, 4'd4, 4'd2, 1'b1, 3'd2},
    {8'h7F, 4'd8, 4'd4, 1'b0, 3'd0},
    {8'hFE, 4'd8, 4'd4, 1'b1, 3'd4},
    {8'hFF, 4'd2, 4'd2, 1'b0, 3'd0},
    {8'hFF, 4'd3, 4'd2, 1'b0, 3'd0},
    {8'hEF, 4'd8, 4'd4, 1'b0, 3'd0},
    {8'h0B, 4'd4, 4'd2, 1'b0, 3'd0},
    {8'h81, 4'd8, 4'd1, 1'b0, 3'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_cfg(input string req, input int w, input bit r, input int f);
    check(prop_valid == 1'b1, req, int'(prop_valid), 1);
    check(cfg_width == w[3:0], req, int'(cfg_width), w);
    check(cfg_reversed == r, req, int'(cfg_reversed), int'(r));
    check(cfg_first_lane == f[2:0], req, int'(cfg_first_lane), f);
  endtask

  // leaves the bench one edge after the pulse (in Detect)
  task automatic pulse_retrain();
    @(negedge clk) retrain = 1'b1;
    @(negedge clk) retrain = 1'b0;
  endtask

  task automatic respond(input logic [1:0] code, input logic [3:0] w);
    @(negedge clk) begin partner_resp = code; partner_width = w; end
    @(negedge clk) partner_resp = 2'd0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: values during reset and right after release
    check(restart_detect == 1'b1, "R1 restart in reset", int'(restart_detect), 1);
    check(link_up == 1'b0 && neg_width == 4'd0, "R1 link down", int'(neg_width), 0);
    rst_n = 1'b1;
    check(prop_valid == 1'b0, "R1 no proposal before edge", int'(prop_valid), 0);
    @(negedge clk);
    check_cfg("R1 first proposal", 8, 1'b0, 0);

    // R2 R3 R4: table walk
    for (int i = 0; i < NV; i++) begin
      lane_ok = VEC[i][19:12];
      max_width = VEC[i][11:8];
      pulse_retrain();
      check(restart_detect == 1'b1, "R9 restart pulse", int'(restart_detect), 1);
      @(negedge clk);
      check_cfg(VEC[i][3] ? "R3 reversed proposal" : "R2 normal proposal",
                int'(VEC[i][7:4]), VEC[i][3], int'(VEC[i][2:0]));
      respond(2'd1, 4'd0);
      check(link_up == 1'b1, "R4 link formed", int'(link_up), 1);
      check(neg_width == VEC[i][7:4], "R4 status width", int'(neg_width), int'(VEC[i][7:4]));
    end

    // R6 R5: counter proposals on the lane-1-bad x4 case
    lane_ok = 8'h0D; max_width = 4'd4;
    pulse_retrain();
    @(negedge clk);
    check_cfg("R3 doc example", 2, 1'b1, 2);
    respond(2'd2, 4'd2);
    check_cfg("R6 counter on bad lane ignored", 2, 1'b1, 2);
    check(link_up == 1'b0, "R6 no link", int'(link_up), 0);
    respond(2'd2, 4'd3);
    check_cfg("R6 non power of two ignored", 2, 1'b1, 2);
    respond(2'd2, 4'd8);
    check_cfg("R6 above ceiling ignored", 2, 1'b1, 2);
    respond(2'd2, 4'd1);
    check(link_up == 1'b1 && neg_width == 4'd1, "R5 counter link width", int'(neg_width), 1);
    check(cfg_reversed == 1'b0 && cfg_first_lane == 3'd0, "R5 counter normal lane 0",
          int'(cfg_reversed), 0);

    // R7: numbering failure blocks reversal on retries
    pulse_retrain();
    @(negedge clk);
    check_cfg("R8 reversal after retrain", 2, 1'b1, 2);
    @(negedge clk) partner_resp = 2'd3;
    @(negedge clk) partner_resp = 2'd0;
    check(restart_detect == 1'b1, "R7 restart after fail", int'(restart_detect), 1);
    @(negedge clk);
    check_cfg("R7 retry normal only", 1, 1'b0, 0);
    respond(2'd3, 4'd0);
    check(restart_detect == 1'b1, "R7 second restart", int'(restart_detect), 1);
    @(negedge clk);
    check_cfg("R7 still normal", 1, 1'b0, 0);
    respond(2'd1, 4'd0);
    check(link_up == 1'b1 && neg_width == 4'd1, "R7 x1 on lane 0", int'(neg_width), 1);

    // R8: forming a link lifted the block -> force Detect via a fail path
    pulse_retrain();
    @(negedge clk);
    check_cfg("R8 cleared by link then retrain", 2, 1'b1, 2);
    respond(2'd3, 4'd0);
    @(negedge clk);
    check_cfg("R7 blocked again", 1, 1'b0, 0);
    pulse_retrain();
    @(negedge clk);
    check_cfg("R8 retrain lifts block", 2, 1'b1, 2);

    // R9: retrain while linked with lowered ceiling
    lane_ok = 8'hFF; max_width = 4'd8;
    pulse_retrain();
    @(negedge clk);
    respond(2'd1, 4'd0);
    check(neg_width == 4'd8, "R9 wide link", int'(neg_width), 8);
    max_width = 4'd2;
    pulse_retrain();
    check(neg_width == 4'd0 && link_up == 1'b0, "R9 status cleared", int'(neg_width), 0);
    @(negedge clk);
    check_cfg("R9 new ceiling", 2, 1'b0, 0);

    // R10: no usable lane in either orientation
    lane_ok = 8'h7E; max_width = 4'd8;
    pulse_retrain();
    repeat (4) @(negedge clk);
    check(prop_valid == 1'b0 && restart_detect == 1'b0, "R10 no proposal", int'(prop_valid), 0);
    check(cfg_width == 4'd0 && link_up == 1'b0 && neg_width == 4'd0, "R10 width zero",
          int'(cfg_width), 0);
    respond(2'd1, 4'd0);
    check(link_up == 1'b0, "R10 accept ignored while down", int'(link_up), 0);
    lane_ok = 8'hFF;
    pulse_retrain();
    @(negedge clk);
    check_cfg("R10 recovers on retrain", 8, 1'b0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule